// File: doc/BRIEF.md
# Buffered I2C Slave Receiver

This block is an I2C target that listens for its own 7-bit address followed by a write direction bit. When it sees that address and address acknowledge is enabled, it acknowledges, raises its interrupt, reports status 60h and holds SCL low. While SCL is held, the host programs how many bytes to take and clears the interrupt. The block then receives that many bytes into a local buffer, filling it from location 0 upward. Every byte is acknowledged except, optionally, the final one.

A flag in the count register chooses what happens to the final byte of a sequence. When the flag is clear, the final byte is acknowledged and the bus stays held, so the host can arm another sequence without a new address phase. When the flag is set, the final byte is not acknowledged and the block returns to the unaddressed state. A STOP or repeated START from the controller ends a sequence early and reports how many complete bytes arrived.

The host side is a small register port with four locations: control, status, count and data. SCL and SDA are sampled through synchronizers. Each line is driven only as an open-drain low through an output enable.

Top module: `i2c_buffered_rx`

## Requirements
- R1: After reset the interrupt and both line enables are low, status reads F8h, and control and count read 00h.
- R2: An address byte whose upper seven bits equal OWN_ADDR and whose bit 0 is 0, received while control bit 0 (address acknowledge enable) is 1, is acknowledged and sets the interrupt with status 60h. Any other address byte, or any address byte while control bit 0 is 0, is not acknowledged and leaves the interrupt low.
- R3: Writing the count register (select 2) with bit 7 as the last-byte flag and bits 6:0 as the byte count (1 to BUF_DEPTH) arms a sequence. The write sets the buffer write pointer, the data read pointer and the received count to 0.
- R4: Received bytes are stored in consecutive buffer locations starting at 0. Every byte before the final one of a sequence is acknowledged.
- R5: When the byte count is reached, the block sets the interrupt. If the last-byte flag is 0, the final byte is acknowledged and status is 80h. If the flag is 1, the final byte is not acknowledged, status is 88h, and after the interrupt is cleared the block ignores the bus until the next START.
- R6: After an address acknowledge or a completed sequence, SCL is held low while the interrupt is pending. It is released once the host writes control (select 0) with bit 1 equal to 0.
- R7: After a sequence that ends with status 80h, a further sequence can be armed and received without a new START or address.
- R8: A STOP or repeated START while the block is receiving sets the interrupt with status A0h, with the count reporting the complete bytes received, and does not hold SCL. After a repeated START the block decodes a new address.
- R9: Reading count (select 2) returns the last-byte flag in bit 7 and the received count in bits 6:0. Successive reads of data (select 3) return the buffer from location 0 upward. The read pointer returns to 0 whenever the interrupt is set or count is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 control, 1 status, 2 count, 3 data |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (advances data pointer) |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for the current select |
| irq_o | output | 1 | Interrupt, active high |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
The bench builds the block with BUF_DEPTH set to 12 and OWN_ADDR set to 55h. The small buffer makes it cheap to run every byte count from 1 to the buffer size with both settings of the last-byte flag, and to check the data and reported count of each sequence. All 256 address bytes are swept, covering matches, near misses and the read direction. The same build runs chained sequences and early termination by STOP and by repeated START in the middle of a sequence.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_HOLD
  } rx_state_e;

  localparam logic [7:0] STS_IDLE      = 8'hF8;
  localparam logic [7:0] STS_ADDR_ACK  = 8'h60;
  localparam logic [7:0] STS_DATA_ACK  = 8'h80;
  localparam logic [7:0] STS_DATA_NACK = 8'h88;
  localparam logic [7:0] STS_BUS_END   = 8'hA0;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_DATA   = 2'd3;
endpackage

// File: rtl/i2cbr_bus_sense.sv
module i2cbr_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] scl_sh, sda_sh;
  logic          scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[NS-2:0], scl_i};
      sda_sh   <= {sda_sh[NS-2:0], sda_i};
      scl_prev <= scl_sh[NS-1];
      sda_prev <= sda_sh[NS-1];
    end
  end

  assign scl_lvl   = scl_sh[NS-1];
  assign sda_lvl   = sda_sh[NS-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cbr_rx_buf.sv
module i2cbr_rx_buf #(
  parameter int BUF_DEPTH = 68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wptr_clr,
  input  logic       rd_adv,
  input  logic       rptr_clr,
  output logic [7:0] rd_data
);
  localparam int PTRW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [PTRW-1:0] LAST_LOC = PTRW'(BUF_DEPTH - 1);

  logic [7:0]      mem [BUF_DEPTH];
  logic [PTRW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;

  always_comb begin
    wptr_d = wptr_q;
    if (wptr_clr)   wptr_d = '0;
    else if (wr_en) wptr_d = (wptr_q == LAST_LOC) ? '0 : wptr_q + 1'b1;
    rptr_d = rptr_q;
    if (rptr_clr)    rptr_d = '0;
    else if (rd_adv) rptr_d = (rptr_q == LAST_LOC) ? '0 : rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wptr_clr) mem[wptr_q] <= wr_data;
  end

  assign rd_data = mem[rptr_q];

  p_wptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= LAST_LOC);
  p_rptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= LAST_LOC);
endmodule

// File: rtl/i2cbr_rx_fsm.sv
module i2cbr_rx_fsm
  import i2cbr_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       ack_en,
  input  logic       cnt_wr,
  input  logic [7:0] cnt_wdata,
  input  logic       irq_clr,
  output logic       irq_o,
  output logic [7:0] status_o,
  output logic       last_o,
  output logic [6:0] rcvcnt_o,
  output logic       buf_we,
  output logic [7:0] buf_wdata,
  output logic       wptr_clr,
  output logic       seq_end,
  output logic       sda_oe_o,
  output logic       scl_oe_o
);
  rx_state_e  state_q, state_d;
  logic [3:0] bitcnt_q, bitcnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic       sda_oe_q, sda_oe_d;
  logic       irq_q, irq_d, irq_set;
  logic [7:0] status_q, status_d;
  logic [6:0] target_q, target_d;
  logic       last_q, last_d;
  logic [6:0] rcvcnt_q, rcvcnt_d, rcv_inc;
  logic       ack_q, ack_d, final_q, final_d, resume_q, resume_d;
  logic       receiving, byte_done, is_final;

  assign rcv_inc   = rcvcnt_q + 7'd1;
  assign receiving = (state_q == ST_DATA) || (state_q == ST_DACK);
  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign is_final  = (rcv_inc >= target_q);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    sda_oe_d = sda_oe_q;
    status_d = status_q;
    target_d = target_q;
    last_d   = last_q;
    rcvcnt_d = rcvcnt_q;
    ack_d    = ack_q;
    final_d  = final_q;
    resume_d = resume_q;
    irq_set  = 1'b0;
    buf_we   = 1'b0;
    wptr_clr = cnt_wr;

    case (state_q)
      ST_ADDR, ST_DATA: begin
        if (scl_rise) begin
          shreg_d  = {shreg_q[6:0], sda_lvl};
          bitcnt_d = bitcnt_q + 4'd1;
        end
        if (byte_done) begin
          bitcnt_d = 4'd0;
          if (state_q == ST_ADDR) begin
            if (shreg_q[7:1] == OWN_ADDR && !shreg_q[0] && ack_en) begin
              state_d  = ST_AACK;
              sda_oe_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            buf_we   = 1'b1;
            rcvcnt_d = rcv_inc;
            final_d  = is_final;
            ack_d    = !(is_final && last_q);
            sda_oe_d = !(is_final && last_q);
            state_d  = ST_DACK;
          end
        end
      end
      ST_AACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          irq_set  = 1'b1;
          status_d = STS_ADDR_ACK;
          rcvcnt_d = '0;
          wptr_clr = 1'b1;
          resume_d = 1'b1;
          state_d  = ST_HOLD;
        end
      end
      ST_DACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          if (final_q) begin
            irq_set  = 1'b1;
            status_d = ack_q ? STS_DATA_ACK : STS_DATA_NACK;
            resume_d = ack_q;
            state_d  = ST_HOLD;
          end else begin
            state_d = ST_DATA;
          end
        end
      end
      ST_HOLD: begin
        if (!irq_q) begin
          state_d = resume_q ? ST_DATA : ST_IDLE;
          if (resume_q) rcvcnt_d = '0;
        end
      end
      default: ;
    endcase

    if (start_det || stop_det) begin
      if (receiving) begin
        irq_set  = 1'b1;
        status_d = STS_BUS_END;
      end
      sda_oe_d = 1'b0;
      bitcnt_d = 4'd0;
      state_d  = start_det ? ST_ADDR : ST_IDLE;
    end

    if (cnt_wr) begin
      target_d = cnt_wdata[6:0];
      last_d   = cnt_wdata[7];
      rcvcnt_d = '0;
    end

    irq_d = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      sda_oe_q <= 1'b0;
      irq_q    <= 1'b0;
      status_q <= STS_IDLE;
      target_q <= '0;
      last_q   <= 1'b0;
      rcvcnt_q <= '0;
      ack_q    <= 1'b0;
      final_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      sda_oe_q <= sda_oe_d;
      irq_q    <= irq_d;
      status_q <= status_d;
      target_q <= target_d;
      last_q   <= last_d;
      rcvcnt_q <= rcvcnt_d;
      ack_q    <= ack_d;
      final_q  <= final_d;
      resume_q <= resume_d;
    end
  end

  assign irq_o     = irq_q;
  assign status_o  = status_q;
  assign last_o    = last_q;
  assign rcvcnt_o  = rcvcnt_q;
  assign buf_wdata = shreg_q;
  assign seq_end   = irq_set;
  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = (state_q == ST_HOLD) && irq_q;

  p_sda_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !scl_lvl);
  p_addr_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK && scl_fall && !start_det && !stop_det)
      |=> (irq_q && status_q == STS_ADDR_ACK));
  p_nack_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && byte_done && last_q && is_final && !start_det && !stop_det)
      |=> !sda_oe_q);
  p_bus_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && receiving) |=> (irq_q && status_q == STS_BUS_END && !scl_oe_o));
  p_release_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !scl_oe_o);
endmodule

// File: rtl/i2c_buffered_rx.sv
module i2c_buffered_rx
  import i2cbr_pkg::*;
#(
  parameter int         BUF_DEPTH   = 68,
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq_o,
  input  logic       scl_i,
  output logic       scl_oe_o,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic ack_en_q, ack_en_d;
  logic cnt_wr, irq_clr, rd_adv;
  logic [7:0] status, buf_wdata, buf_rdata;
  logic [6:0] rcvcnt;
  logic last, buf_we, wptr_clr, seq_end;

  assign cnt_wr  = host_wr && (host_sel == SEL_COUNT);
  assign irq_clr = host_wr && (host_sel == SEL_CTRL) && !host_wdata[1];
  assign rd_adv  = host_rd && (host_sel == SEL_DATA);

  always_comb begin
    ack_en_d = ack_en_q;
    if (host_wr && host_sel == SEL_CTRL) ack_en_d = host_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ack_en_q <= 1'b0;
    else             ack_en_q <= ack_en_d;
  end

  i2cbr_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cbr_rx_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_en(ack_en_q), .cnt_wr(cnt_wr), .cnt_wdata(host_wdata), .irq_clr(irq_clr),
    .irq_o(irq_o), .status_o(status), .last_o(last), .rcvcnt_o(rcvcnt),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .wptr_clr(wptr_clr), .seq_end(seq_end),
    .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o)
  );

  i2cbr_rx_buf #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(buf_we), .wr_data(buf_wdata),
    .wptr_clr(wptr_clr), .rd_adv(rd_adv), .rptr_clr(cnt_wr | seq_end),
    .rd_data(buf_rdata)
  );

  always_comb begin
    case (host_sel)
      SEL_CTRL:   host_rdata = {6'b0, irq_o, ack_en_q};
      SEL_STATUS: host_rdata = status;
      SEL_COUNT:  host_rdata = {last, rcvcnt};
      default:    host_rdata = buf_rdata;
    endcase
  end
endmodule

// File: tb/test_i2c_buffered_rx.sv
module test_i2c_buffered_rx;
  localparam int         DEPTH = 12;
  localparam logic [6:0] OWN   = 7'h55;
  localparam int         H     = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] hsel;
  logic       hwr, hrd;
  logic [7:0] hwdata, hrdata;
  logic       irq, scl_oe, sda_oe;
  logic       m_scl_low, m_sda_low;
  logic       scl, sda;

  assign scl = !(m_scl_low | scl_oe);
  assign sda = !(m_sda_low | sda_oe);

  i2c_buffered_rx #(.BUF_DEPTH(DEPTH), .OWN_ADDR(OWN), .SYNC_STAGES(2)) i_i2c_buffered_rx (
    .clk(clk), .rst_n(rst_n), .host_sel(hsel), .host_wr(hwr), .host_rd(hrd),
    .host_wdata(hwdata), .host_rdata(hrdata), .irq_o(irq),
    .scl_i(scl), .scl_oe_o(scl_oe), .sda_i(sda), .sda_oe_o(sda_oe)
  );

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); hsel = s; hwdata = d; hwr = 1'b1;
    @(negedge clk); hwr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); hsel = s; hrd = 1'b1;
    #1 d = hrdata;
    @(negedge clk); hrd = 1'b0;
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wt(H);
    m_scl_low = 1'b0; wait (scl === 1'b1); wt(H);
    m_sda_low = 1'b1; wt(H);
    m_scl_low = 1'b1; wt(H);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wt(H);
    m_scl_low = 1'b0; wait (scl === 1'b1); wt(H);
    m_sda_low = 1'b0; wt(H);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = !b; wt(H);
    m_scl_low = 1'b0; wait (scl === 1'b1); wt(H/2);
    r = sda; wt(H/2);
    m_scl_low = 1'b1; wt(2);
  endtask

  task automatic m_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = !r;
  endtask

  function automatic logic [7:0] pat(input int n, input int i, input int lb);
    return 8'((n * 37 + i * 11 + lb * 5 + 3) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       ack;
    rst_n = 1'b0; hsel = 2'd0; hwr = 1'b0; hrd = 1'b0; hwdata = 8'h00;
    m_scl_low = 1'b0; m_sda_low = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    hr(2'd1, d); chk("R1 status", d, 8'hF8);
    hr(2'd0, d); chk("R1 ctrl", d, 8'h00);
    hr(2'd2, d); chk("R1 count", d, 8'h00);

    // R2 acknowledge disabled: own address is ignored
    m_start(); m_byte({OWN, 1'b0}, ack); wt(H);
    chk("R2 no ack when disabled", ack, 0);
    chk("R2 no irq when disabled", irq, 0);
    m_stop();

    hw(2'd0, 8'h01);
    // R2 sweep of every address byte
    for (int a = 0; a < 256; a++) begin
      int exp_ack;
      exp_ack = ((a >> 1) == int'(OWN) && (a & 1) == 0) ? 1 : 0;
      m_start(); m_byte(8'(a), ack); wt(H);
      chk($sformatf("R2 ack addr %0h", a), ack, exp_ack);
      chk($sformatf("R2 irq addr %0h", a), irq, exp_ack);
      if (exp_ack == 1) begin
        hr(2'd1, d); chk("R2 status 60h", d, 8'h60);
        wt(20);
        chk("R6 scl held after address", scl_oe, 1);
        hw(2'd0, 8'h01); wt(4);
        chk("R6 scl released after clear", scl_oe, 0);
        m_stop(); wt(4);
        // R8 STOP with no data
        chk("R8 irq on stop", irq, 1);
        hr(2'd1, d); chk("R8 status A0h", d, 8'hA0);
        hr(2'd2, d); chk("R8 zero count", d & 8'h7F, 0);
        chk("R8 no stretch", scl_oe, 0);
        hw(2'd0, 8'h01);
      end else begin
        m_stop();
      end
    end

    // R3 R4 R5 R9 sweep over counts and last-byte flag
    for (int lb = 0; lb < 2; lb++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        m_start(); m_byte({OWN, 1'b0}, ack); wt(H);
        chk("R2 own ack", ack, 1);
        hw(2'd2, 8'((lb << 7) | n));
        hr(2'd2, d); chk("R3 count write clears received", d, (lb << 7));
        hw(2'd0, 8'h01);
        for (int i = 0; i < n; i++) begin
          m_byte(pat(n, i, lb), ack);
          if (i < n - 1) chk($sformatf("R4 ack n=%0d i=%0d", n, i), ack, 1);
          else           chk($sformatf("R5 final ack n=%0d lb=%0d", n, lb), ack, (lb == 0) ? 1 : 0);
        end
        wt(H);
        chk("R5 irq at count", irq, 1);
        chk("R6 scl held after sequence", scl_oe, 1);
        hr(2'd1, d); chk("R5 status", d, (lb == 0) ? 8'h80 : 8'h88);
        hr(2'd2, d); chk("R9 count readback", d, (lb << 7) | n);
        for (int i = 0; i < n; i++) begin
          hr(2'd3, d); chk($sformatf("R9 data n=%0d i=%0d", n, i), d, pat(n, i, lb));
        end
        hw(2'd0, 8'h01); wt(4);
        chk("R6 released", scl_oe, 0);
        m_stop(); wt(4);
        if (lb == 1) begin
          chk("R5 unaddressed after nack", irq, 0);
        end else begin
          chk("R8 stop after chained ack", irq, 1);
          hr(2'd1, d); chk("R8 status", d, 8'hA0);
          hr(2'd2, d); chk("R8 count", d, 0);
          hw(2'd0, 8'h01);
        end
      end
    end

    // R7 chained sequences without a new address
    m_start(); m_byte({OWN, 1'b0}, ack); wt(H);
    hw(2'd2, 8'h03); hw(2'd0, 8'h01);
    for (int i = 0; i < 3; i++) m_byte(pat(3, i, 7), ack);
    wt(H);
    hr(2'd1, d); chk("R7 first part status", d, 8'h80);
    hw(2'd2, 8'h82); hw(2'd0, 8'h01);
    for (int i = 0; i < 2; i++) begin
      m_byte(pat(9, i, 7), ack);
      chk("R7 second part ack", ack, (i == 0) ? 1 : 0);
    end
    wt(H);
    hr(2'd1, d); chk("R7 second part status", d, 8'h88);
    hr(2'd2, d); chk("R7 second part count", d, 8'h82);
    for (int i = 0; i < 2; i++) begin
      hr(2'd3, d); chk("R7 second part data", d, pat(9, i, 7));
    end
    hw(2'd0, 8'h01); m_stop();

    // R8 repeated START truncates a sequence
    m_start(); m_byte({OWN, 1'b0}, ack); wt(H);
    hw(2'd2, 8'h05); hw(2'd0, 8'h01);
    m_byte(8'hC3, ack); m_byte(8'h3C, ack);
    m_start(); wt(4);
    chk("R8 irq on restart", irq, 1);
    chk("R8 no stretch on restart", scl_oe, 0);
    hr(2'd1, d); chk("R8 restart status", d, 8'hA0);
    hr(2'd2, d); chk("R8 restart count", d, 2);
    hr(2'd3, d); chk("R8 data 0", d, 8'hC3);
    hr(2'd3, d); chk("R8 data 1", d, 8'h3C);
    hw(2'd0, 8'h01);
    m_byte({OWN, 1'b0}, ack); wt(H);
    chk("R8 readdress after restart", ack, 1);
    hr(2'd1, d); chk("R8 readdress status", d, 8'h60);
    hw(2'd0, 8'h01); m_stop(); wt(4);
    hw(2'd0, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule